// File: doc/BRIEF.md
# Multi-Amount Shift Unit

A purely combinational shift datapath with one data operand and several shift-amount lanes, each lane gated by its own valid bit. In left mode the operand is shifted by every enabled amount at once and the shifted copies are merged with a bitwise OR. A single enabled lane therefore gives an ordinary left shift, and several lanes with data equal to one build one-hot or multi-hot masks in one pass.

In right mode the unit does a sign-preserving arithmetic shift by the amount on lane 0 only. A zero-extend flag first turns the operand into a non-negative value, so the arithmetic shift then behaves as a logical shift. The amounts are runtime values, so each lane and the right path is a logarithmic barrel shifter.

The result is wider than the operand: `OUT_W = DATA_W + 2**AMT_W - 1`. No left-shifted bit is lost, and right-shift results are sign-extended or zero-extended to the full width.

Top module: `mshift_unit`

## Requirements
- R1: In left mode (mode_i = 0), with exactly one valid lane holding amount k, res_o equals data_i zero-extended to OUT_W and shifted left by k.
- R2: In left mode with several valid lanes, res_o is the bitwise OR of data_i shifted left by each valid lane's amount. For example, data 1 with amounts 1 and 2 gives 6.
- R3: In left mode a lane whose valid bit is low adds nothing to the result. With no valid lane, res_o is zero.
- R4: res_o is OUT_W = DATA_W + 2**AMT_W - 1 bits wide. A left shift by the largest amount, 2**AMT_W - 1, places data_i bit DATA_W-1 at res_o bit OUT_W-1 with no bit lost.
- R5: In right mode (mode_i = 1) with zext_i = 0, data_i is taken as signed, sign-extended to OUT_W and shifted right arithmetically. Copies of the sign bit fill the vacated upper positions.
- R6: In right mode with zext_i = 1, data_i is zero-extended before the arithmetic shift, so the result is a logical right shift and its upper bits are zero.
- R7: In right mode only lane 0 is used. The amounts and valid bits of lanes 1 and above have no effect on res_o.
- R8: In right mode with lane 0 not valid, the shift amount is zero and res_o is the extended operand.
- R9: In left mode zext_i has no effect on res_o.
- R10: Lane k's amount sits in amt_i bits [k*AMT_W +: AMT_W] and its valid bit in vld_i bit k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | DATA_W | Operand to be shifted |
| amt_i | input | LANES*AMT_W | Packed shift amounts, lane k at bits [k*AMT_W +: AMT_W] |
| vld_i | input | LANES | Per-lane valid bits |
| mode_i | input | 1 | 0 = left shift with OR merge, 1 = arithmetic right shift by lane 0 |
| zext_i | input | 1 | Zero-extend the operand before a right shift |
| res_o | output | OUT_W | Shift result |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between the inputs and res_o. The driver applies each stimulus just after a rising edge and queues the expected word. The monitor pops and compares that word at the following falling edge, half a period later, once the combinational paths have settled. Exactly one item is in flight per cycle, so a result can never be compared against the wrong stimulus.

// File: rtl/mshift_pkg.sv
package mshift_pkg;

    typedef enum logic {
        SHIFT_LEFT_OR     = 1'b0,
        SHIFT_RIGHT_ARITH = 1'b1
    } shift_mode_e;

    function automatic int result_width(input int data_w, input int amt_w);
        return data_w + (1 << amt_w) - 1;
    endfunction

endpackage

// File: rtl/mshift_left_lane.sv
module mshift_left_lane #(
    parameter int DATA_W = 16,
    parameter int AMT_W  = 4,
    parameter int OUT_W  = 31
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              vld_i,
    output logic [OUT_W-1:0]  res_o
);

    localparam int PAD_W = OUT_W - DATA_W;

    logic [AMT_W:0][OUT_W-1:0] stage_d;

    assign stage_d[0] = {{PAD_W{1'b0}}, data_i};

    // one barrel stage per amount bit, stage s moves by 2**s
    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage_d[s+1] = amt_i[s] ? (stage_d[s] << STEP) : stage_d[s];
    end

    assign res_o = vld_i ? stage_d[AMT_W] : '0;

endmodule

// File: rtl/mshift_or_merge.sv
module mshift_or_merge #(
    parameter int LANES = 4,
    parameter int OUT_W = 31
) (
    input  logic [LANES-1:0][OUT_W-1:0] lanes_i,
    output logic [OUT_W-1:0]            res_o
);

    always_comb begin
        res_o = '0;
        for (int k = 0; k < LANES; k++) begin
            res_o = res_o | lanes_i[k];
        end
    end

endmodule

// File: rtl/mshift_right.sv
module mshift_right #(
    parameter int DATA_W = 16,
    parameter int AMT_W  = 4,
    parameter int OUT_W  = 31
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              zext_i,
    output logic [OUT_W-1:0]  res_o
);

    localparam int PAD_W = OUT_W - DATA_W;

    logic                      fill_d;
    logic [AMT_W:0][OUT_W-1:0] stage_d;

    // masking to a positive value turns the arithmetic shift into a logical one
    assign fill_d     = zext_i ? 1'b0 : data_i[DATA_W-1];
    assign stage_d[0] = {{PAD_W{fill_d}}, data_i};

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage_d[s+1] = amt_i[s]
            ? {{STEP{stage_d[s][OUT_W-1]}}, stage_d[s][OUT_W-1:STEP]}
            : stage_d[s];
    end

    assign res_o = stage_d[AMT_W];

endmodule

// File: rtl/mshift_unit.sv
module mshift_unit #(
    parameter int DATA_W = 16,
    parameter int LANES  = 4,
    parameter int AMT_W  = 4,
    parameter int OUT_W  = mshift_pkg::result_width(DATA_W, AMT_W)
) (
    input  logic [DATA_W-1:0]      data_i,
    input  logic [LANES*AMT_W-1:0] amt_i,
    input  logic [LANES-1:0]       vld_i,
    input  logic                   mode_i,
    input  logic                   zext_i,
    output logic [OUT_W-1:0]       res_o
);
    import mshift_pkg::*;

    typedef struct packed {
        logic [OUT_W-1:0] left;
        logic [OUT_W-1:0] right;
    } shift_pair_t;

    shift_mode_e                 mode_d;
    logic [LANES-1:0][OUT_W-1:0] lane_res_d;
    logic [AMT_W-1:0]            right_amt_d;
    shift_pair_t                 pair_d;
    logic [OUT_W-1:0]            res_d;

    assign mode_d = shift_mode_e'(mode_i);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        mshift_left_lane #(
            .DATA_W (DATA_W),
            .AMT_W  (AMT_W),
            .OUT_W  (OUT_W)
        ) u_lane (
            .data_i (data_i),
            .amt_i  (amt_i[k*AMT_W +: AMT_W]),
            .vld_i  (vld_i[k]),
            .res_o  (lane_res_d[k])
        );
    end

    mshift_or_merge #(
        .LANES (LANES),
        .OUT_W (OUT_W)
    ) u_merge (
        .lanes_i (lane_res_d),
        .res_o   (pair_d.left)
    );

    // right mode reads lane 0 only; an idle lane 0 means no shift
    assign right_amt_d = vld_i[0] ? amt_i[AMT_W-1:0] : '0;

    mshift_right #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W),
        .OUT_W  (OUT_W)
    ) u_right (
        .data_i (data_i),
        .amt_i  (right_amt_d),
        .zext_i (zext_i),
        .res_o  (pair_d.right)
    );

    always_comb begin
        unique case (mode_d)
            SHIFT_RIGHT_ARITH: res_d = pair_d.right;
            default:           res_d = pair_d.left;
        endcase
    end

    assign res_o = res_d;

endmodule

// File: rtl/mshift_unit_chk.sv
module mshift_unit_chk #(
    parameter int DATA_W = 16,
    parameter int LANES  = 4,
    parameter int AMT_W  = 4,
    parameter int OUT_W  = 31
) (
    input logic [DATA_W-1:0]      data_i,
    input logic [LANES*AMT_W-1:0] amt_i,
    input logic [LANES-1:0]       vld_i,
    input logic                   mode_i,
    input logic                   zext_i,
    input logic [OUT_W-1:0]       res_o
);

    logic zero_amt_seen;

    always_comb begin
        zero_amt_seen = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if (vld_i[k] && amt_i[k*AMT_W +: AMT_W] == '0) zero_amt_seen = 1'b1;
        end

        // R1: bit 0 can be set only by a valid lane with amount zero
        if (!mode_i) begin
            assert_left_lsb_R1: assert (res_o[0] == (data_i[0] & zero_amt_seen));
        end

        // R3: no valid lane in left mode gives an all-zero result
        if (!mode_i && vld_i == '0) begin
            assert_left_none_R3: assert (res_o == '0);
        end

        // R5: a negative signed operand keeps its sign at the top
        if (mode_i && !zext_i && data_i[DATA_W-1]) begin
            assert_sign_fill_R5: assert (res_o[OUT_W-1]);
        end

        // R6: a zero-extended operand never yields a set top bit
        if (mode_i && zext_i) begin
            assert_logical_top_R6: assert (!res_o[OUT_W-1]);
        end

        // R8: idle lane 0 in right mode passes the operand through
        if (mode_i && !vld_i[0]) begin
            assert_right_idle_R8: assert (res_o[DATA_W-1:0] == data_i);
        end
    end

endmodule

bind mshift_unit mshift_unit_chk #(
    .DATA_W (DATA_W),
    .LANES  (LANES),
    .AMT_W  (AMT_W),
    .OUT_W  (OUT_W)
) u_chk (
    .data_i (data_i),
    .amt_i  (amt_i),
    .vld_i  (vld_i),
    .mode_i (mode_i),
    .zext_i (zext_i),
    .res_o  (res_o)
);

// File: tb/mshift_unit_tb.sv
module mshift_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int LANES      = 4;
    localparam int AMT_W      = 4;
    localparam int OUT_W      = DATA_W + (1 << AMT_W) - 1;
    localparam int MAX_AMT    = (1 << AMT_W) - 1;

    typedef struct {
        logic [OUT_W-1:0] exp;
        string            tag;
    } item_t;

    logic                   clk = 1'b0;
    logic [DATA_W-1:0]      data_i = '0;
    logic [LANES*AMT_W-1:0] amt_i = '0;
    logic [LANES-1:0]       vld_i = '0;
    logic                   mode_i = 1'b0;
    logic                   zext_i = 1'b0;
    logic [OUT_W-1:0]       res_o;

    item_t q[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mshift_unit #(
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .AMT_W  (AMT_W)
    ) u_dut (
        .data_i (data_i),
        .amt_i  (amt_i),
        .vld_i  (vld_i),
        .mode_i (mode_i),
        .zext_i (zext_i),
        .res_o  (res_o)
    );

    function automatic logic [OUT_W-1:0] model(
        input logic [DATA_W-1:0]      d,
        input logic [LANES*AMT_W-1:0] a,
        input logic [LANES-1:0]       v,
        input logic                   m,
        input logic                   z
    );
        logic [OUT_W-1:0] r;
        logic signed [63:0] w;
        int sh;
        r = '0;
        if (!m) begin
            for (int k = 0; k < LANES; k++) begin
                if (v[k]) begin
                    sh = int'(a[k*AMT_W +: AMT_W]);
                    for (int i = 0; i < DATA_W; i++) begin
                        if (d[i]) r[i+sh] = 1'b1;
                    end
                end
            end
        end else begin
            sh = v[0] ? int'(a[AMT_W-1:0]) : 0;
            w  = z ? {{(64-DATA_W){1'b0}}, d} : {{(64-DATA_W){d[DATA_W-1]}}, d};
            w  = w >>> sh;
            r  = w[OUT_W-1:0];
        end
        return r;
    endfunction

    task automatic drive(
        input logic [DATA_W-1:0]      d,
        input logic [LANES*AMT_W-1:0] a,
        input logic [LANES-1:0]       v,
        input logic                   m,
        input logic                   z,
        input string                  tag
    );
        item_t it;
        @(posedge clk);
        data_i = d;
        amt_i  = a;
        vld_i  = v;
        mode_i = m;
        zext_i = z;
        it.exp = model(d, a, v, m, z);
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic expect_direct(input logic [OUT_W-1:0] got,
                                 input logic [OUT_W-1:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: result is combinational, so it is due half a period after drive
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_checks++;
            if (res_o !== it.exp) begin
                n_fails++;
                $display("FAIL %s: got %h expected %h", it.tag, res_o, it.exp);
            end
        end
    end

    function automatic logic [LANES*AMT_W-1:0] pack4(input int a0, input int a1,
                                                     input int a2, input int a3);
        return {AMT_W'(a3), AMT_W'(a2), AMT_W'(a1), AMT_W'(a0)};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // idle state: all inputs low, result zero (R3)
        #(CLK_PERIOD/4);
        expect_direct(res_o, '0, "R3 idle");

        drive(16'h00A5, pack4(3, 0, 0, 0), 4'b0001, 1'b0, 1'b0, "R1 single lane");
        drive(16'h0001, pack4(0, 9, 0, 0), 4'b0010, 1'b0, 1'b0, "R1 lane1 alone");
        drive(16'h0001, pack4(1, 2, 0, 0), 4'b0011, 1'b0, 1'b0, "R2 one-hot pair");
        drive(16'h0003, pack4(0, 4, 8, 12), 4'b1111, 1'b0, 1'b0, "R2 four lanes");
        drive(16'hFFFF, pack4(5, 6, 7, 8), 4'b0000, 1'b0, 1'b0, "R3 no lane valid");
        drive(16'h0001, pack4(1, 2, 3, 4), 4'b0101, 1'b0, 1'b0, "R3 idle lanes");
        drive(16'h8000, pack4(MAX_AMT, 0, 0, 0), 4'b0001, 1'b0, 1'b0, "R4 max amount");
        drive(16'hFFFF, pack4(MAX_AMT, 0, 0, 0), 4'b0001, 1'b0, 1'b0, "R4 full top");
        drive(16'h8000, pack4(4, 0, 0, 0), 4'b0001, 1'b1, 1'b0, "R5 sign fill");
        drive(16'hF0F0, pack4(MAX_AMT, 0, 0, 0), 4'b0001, 1'b1, 1'b0, "R5 max right");
        drive(16'h8000, pack4(4, 0, 0, 0), 4'b0001, 1'b1, 1'b1, "R6 logical");
        drive(16'hFFFF, pack4(MAX_AMT, 0, 0, 0), 4'b0001, 1'b1, 1'b1, "R6 logical max");
        drive(16'h9234, pack4(2, 7, 9, 11), 4'b1111, 1'b1, 1'b0, "R7 other lanes");
        drive(16'h9234, pack4(2, 0, 0, 0), 4'b0001, 1'b1, 1'b0, "R7 lane0 only");
        drive(16'hC001, pack4(6, 3, 3, 3), 4'b1110, 1'b1, 1'b0, "R8 lane0 idle");
        drive(16'h4321, pack4(2, 5, 0, 0), 4'b0011, 1'b0, 1'b1, "R9 zext in left");
        drive(16'h0001, pack4(1, 3, 5, 7), 4'b1000, 1'b0, 1'b0, "R10 lane3 field");

        // random data and amounts over every enable pattern (R1 R2 R3 R5 R6 R7 R10)
        for (int rep = 0; rep < 24; rep++) begin
            for (int p = 0; p < (1 << LANES); p++) begin
                drive(DATA_W'($urandom), (LANES*AMT_W)'($urandom), LANES'(p),
                      1'b0, 1'($urandom), "R2 random left");
                drive(DATA_W'($urandom), (LANES*AMT_W)'($urandom), LANES'(p),
                      1'b1, 1'($urandom), "R7 random right");
            end
        end

        @(posedge clk);
        @(posedge clk);
        finish_run();
    end

endmodule